// File: doc/BRIEF.md
# GPIO interrupt controller

This block turns a bank of already synchronized GPIO input levels into interrupt requests. Each line can be set to sense a level or an edge. In edge mode it can react to one edge or to both edges. A polarity bit selects high/rising or low/falling. An edge event is held in a sticky per-line latch until software acknowledges it. A level event simply follows the input.

Every line has its own enable bit and its own clear bit. Disabling a line hides its pending state from the output but does not discard a latched edge. To acknowledge a line, software writes its clear bit to 0 and then to 1. Only that 0-to-1 change of the stored bit empties the latch. All enabled pending lines are ORed into one registered request toward the parent interrupt controller.

Configuration uses a simple single-cycle write bus with a combinational read. Each register word holds 32 lines. The per-line raw and masked status vectors are also driven out directly.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset all type, both-edge, polarity, enable and clear bits read 0, irqOut is 0 and masked status is 0. With all lines in level/low mode, an input at 0 reads as raw pending 1.
- R2: A line in level mode (type bit 0) shows a raw status equal to its input when its polarity bit is 1, and equal to the inverted input when it is 0. The status changes in the same cycle as the input. Toggling its clear bit has no effect on that status.
- R3: A line in edge mode (type bit 1) with both-edge bit 0 latches a pending event on a rising input when polarity is 1, and on a falling input when polarity is 0. The opposite edge does not set the latch. An edge is detected by comparing the input with its value in the previous cycle, and the latch reads as set after the next clock edge.
- R4: With the both-edge bit at 1, an edge-mode line latches on either edge whatever its polarity bit. In level mode the both-edge bit has no effect.
- R5: Masked status equals raw status AND the enable bits. Clearing an enable bit does not clear a latched edge, and raw status still shows it.
- R6: A latched edge is cleared only by a write that moves the line's stored clear bit from 0 to 1. Writing 1 over a stored 1, or writing 0, leaves the latch set.
- R7: An edge detected in the same cycle as an acknowledging write wins, and the latch stays set.
- R8: irqOut is the OR of all masked status bits, registered once. It follows a change of masked status one clock later.
- R9: busAddr bits [ADDR_W-1:ADDR_W-3] select the register: 0 type, 1 both-edge, 2 polarity, 3 enable, 4 clear, 5 raw status, 6 masked status, 7 reads zero. The low bits select the word. Line n sits at bit n mod 32 of word n/32. Writable registers read back what was written.
- R10: A write that changes a line's type or polarity bit clears that line's edge latch.
- R11: A latched edge stays set after the input returns to its earlier level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | NUM_LINES | Synchronized GPIO input levels |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register select and word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| rawStatus | output | NUM_LINES | Per-line pending state before masking |
| maskedStatus | output | NUM_LINES | Per-line pending state after masking |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
The bench drives line 37 (word 1, bit 5) through rising, falling and both-edge sensing, and checks that the opposite edge leaves the latch empty. A design with a swapped polarity sense fails these checks. It also fails them if it lets the both-edge bit leak into level mode. The acknowledge tests write 1 over a stored 1 and write 0 alone, which catches a design that clears on any write of 1. They also lay a rising edge on the very cycle of the 0-to-1 write, which catches a design that lets the clear win and drops an event. Masking is toggled while the latch is set, and the request is sampled one cycle before and one cycle after each masked change. This exposes a latch that masking wrongly empties, or a request that is left unregistered or is delayed by an extra cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;

  // Register select codes, upper address bits
  typedef enum logic [SEL_W-1:0] {
    SEL_TYPE   = 3'd0,
    SEL_BOTH   = 3'd1,
    SEL_POL    = 3'd2,
    SEL_EN     = 3'd3,
    SEL_CLR    = 3'd4,
    SEL_RAW    = 3'd5,
    SEL_MASKED = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  // Per-line strobes from control to datapath
  typedef struct packed {
    logic clrRise;   // stored clear bit moves 0 -> 1
    logic cfgChg;    // type or polarity bit changes
  } lineStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int WORDS  = (NUM_LINES + WORD_W - 1) / WORD_W,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W = SEL_W + WIDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] rawStatus,
  input  logic [NUM_LINES-1:0] maskedStatus,
  output logic [NUM_LINES-1:0] edgeMode,
  output logic [NUM_LINES-1:0] bothEdges,
  output logic [NUM_LINES-1:0] polHigh,
  output logic [NUM_LINES-1:0] lineEn,
  output lineStrobe_t          strobes [NUM_LINES]
);

  localparam int PAD_W = WORDS * WORD_W;

  regSel_e            sel;
  logic [WIDX_W-1:0]  widx;
  logic [PAD_W-1:0]   typeR, bothR, polR, enR, clrR;

  assign sel  = regSel_e'(busAddr[ADDR_W-1 -: SEL_W]);
  assign widx = busAddr[WIDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeR <= '0;
      bothR <= '0;
      polR  <= '0;
      enR   <= '0;
      clrR  <= '0;
    end else if (busWe) begin
      for (int w = 0; w < WORDS; w++) begin
        if (widx == WIDX_W'(w)) begin
          case (sel)
            SEL_TYPE: typeR[w*WORD_W +: WORD_W] <= busWdata;
            SEL_BOTH: bothR[w*WORD_W +: WORD_W] <= busWdata;
            SEL_POL:  polR[w*WORD_W +: WORD_W]  <= busWdata;
            SEL_EN:   enR[w*WORD_W +: WORD_W]   <= busWdata;
            SEL_CLR:  clrR[w*WORD_W +: WORD_W]  <= busWdata;
            default:  ;
          endcase
        end
      end
    end
  end

  assign edgeMode  = typeR[NUM_LINES-1:0];
  assign bothEdges = bothR[NUM_LINES-1:0];
  assign polHigh   = polR[NUM_LINES-1:0];
  assign lineEn    = enR[NUM_LINES-1:0];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_strobe
    localparam int LW = i / WORD_W;
    localparam int LB = i % WORD_W;
    logic lineHit;
    assign lineHit = busWe && (widx == WIDX_W'(LW));
    assign strobes[i].clrRise = lineHit && (sel == SEL_CLR) && busWdata[LB] && !clrR[i];
    assign strobes[i].cfgChg  = lineHit &&
        (((sel == SEL_TYPE) && (busWdata[LB] != typeR[i])) ||
         ((sel == SEL_POL)  && (busWdata[LB] != polR[i])));
  end

  logic [PAD_W-1:0] rdSrc;
  always_comb begin
    rdSrc = '0;
    case (sel)
      SEL_TYPE:   rdSrc = typeR;
      SEL_BOTH:   rdSrc = bothR;
      SEL_POL:    rdSrc = polR;
      SEL_EN:     rdSrc = enR;
      SEL_CLR:    rdSrc = clrR;
      SEL_RAW:    rdSrc[NUM_LINES-1:0] = rawStatus;
      SEL_MASKED: rdSrc[NUM_LINES-1:0] = maskedStatus;
      default:    rdSrc = '0;
    endcase
    busRdata = '0;
    if (int'(widx) < WORDS) busRdata = rdSrc[int'(widx)*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [NUM_LINES-1:0] edgeMode,
  input  logic [NUM_LINES-1:0] bothEdges,
  input  logic [NUM_LINES-1:0] polHigh,
  input  logic [NUM_LINES-1:0] lineEn,
  input  lineStrobe_t          strobes [NUM_LINES],
  output logic [NUM_LINES-1:0] rawStatus,
  output logic [NUM_LINES-1:0] maskedStatus,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] prevIn;
  logic [NUM_LINES-1:0] edgeLatch;
  logic [NUM_LINES-1:0] latchNext;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise, fall, hit, keep;
    assign rise = lineIn[i] & ~prevIn[i];
    assign fall = ~lineIn[i] & prevIn[i];
    assign hit  = bothEdges[i] ? (rise | fall) : (polHigh[i] ? rise : fall);
    // A fresh edge outranks any clearing strobe in the same cycle
    assign keep = edgeLatch[i] & ~strobes[i].clrRise & ~strobes[i].cfgChg;
    assign latchNext[i] = edgeMode[i] & (hit | keep);
    assign rawStatus[i] = edgeMode[i] ? edgeLatch[i] : ~(lineIn[i] ^ polHigh[i]);
  end

  assign maskedStatus = rawStatus & lineEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn    <= '0;
      edgeLatch <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevIn    <= lineIn;
      edgeLatch <= latchNext;
      irqOut    <= |maskedStatus;
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int WORDS  = (NUM_LINES + WORD_W - 1) / WORD_W,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W = SEL_W + WIDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  output logic [NUM_LINES-1:0] rawStatus,
  output logic [NUM_LINES-1:0] maskedStatus,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] edgeMode, bothEdges, polHigh, lineEn;
  lineStrobe_t          strobes [NUM_LINES];

  gpio_irq_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus),
    .edgeMode(edgeMode), .bothEdges(bothEdges), .polHigh(polHigh), .lineEn(lineEn),
    .strobes(strobes)
  );

  gpio_irq_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .edgeMode(edgeMode), .bothEdges(bothEdges), .polHigh(polHigh), .lineEn(lineEn),
    .strobes(strobes),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] lineIn,
  input logic                 busWe,
  input logic [NUM_LINES-1:0] rawStatus,
  input logic [NUM_LINES-1:0] maskedStatus,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] edgeModeVec,
  input logic [NUM_LINES-1:0] polVec
);

  // R5: masked status never shows a line that is not raw pending
  a_r5_masked_within_raw: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == '0);

  // R8: request is the registered OR of masked status
  a_r8_irq_registered_or: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|maskedStatus)));

  // R2: level-mode lines track input qualified by polarity
  a_r2_level_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus ^ ~(lineIn ^ polVec)) & ~edgeModeVec) == '0);

  // R11: without a bus write, a set edge latch stays set
  a_r11_edge_latch_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWe) |-> ((($past(rawStatus) & $past(edgeModeVec)) & ~rawStatus) == '0));

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .busWe(busWe),
  .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut),
  .edgeModeVec(edgeMode), .polVec(polHigh)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  import gpio_irq_pkg::*;

  localparam int NL = 64;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] lineIn = '0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] rawStatus, maskedStatus;
  logic          irqOut;

  gpio_irq_unit #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  sampleEv;
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;

  function automatic logic [AW-1:0] mkAddr(regSel_e s, int w);
    return {s, 1'(w)};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(regSel_e s, int w, logic [31:0] d);
    busWe = 1'b1; busAddr = mkAddr(s, w); busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic ack(int w, logic [31:0] m);
    wr(SEL_CLR, w, 32'h0);
    wr(SEL_CLR, w, m);
  endtask

  task automatic expRd(regSel_e s, int w, logic [31:0] e, string tag);
    item_t it;
    busAddr = mkAddr(s, w);
    #1;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  task automatic expIrq(bit e, string tag);
    item_t it;
    #1;
    it.isIrq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    expQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        item_t       it;
        logic [31:0] act;
        it  = expQ.pop_front();
        act = it.isIrq ? {31'b0, irqOut} : busRdata;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expIrq(1'b0, "R1 irq after reset");
    expRd(SEL_RAW, 0, 32'hFFFF_FFFF, "R1 raw default level-low");
    expRd(SEL_MASKED, 0, 32'h0, "R1 masked after reset");
    expRd(SEL_TYPE, 1, 32'h0, "R1 type after reset");
    expRd(SEL_CLR, 0, 32'h0, "R1 clear after reset");

    // R9 map and readback
    wr(SEL_POL, 0, 32'hFFFF_FFFF);
    wr(SEL_POL, 1, 32'hFFFF_FFFF);
    expRd(SEL_POL, 1, 32'hFFFF_FFFF, "R9 polarity readback");
    wr(SEL_EN, 1, 32'h1234_5678);
    expRd(SEL_EN, 1, 32'h1234_5678, "R9 enable readback");
    wr(SEL_EN, 1, 32'h0);
    expRd(SEL_NONE, 0, 32'h0, "R9 code 7 reads zero");
    expRd(SEL_RAW, 0, 32'h0, "R2 level-high with low inputs");

    // R2 level mode on line 3
    lineIn[3] = 1'b1;
    expRd(SEL_RAW, 0, 32'h8, "R2 level follows high input");
    ack(0, 32'h8);
    expRd(SEL_RAW, 0, 32'h8, "R2 clear has no effect in level mode");
    lineIn[3] = 1'b0;
    expRd(SEL_RAW, 0, 32'h0, "R2 level drops with input");

    // R3 rising edge on line 37 = word 1 bit 5
    wr(SEL_TYPE, 1, 32'h20);
    lineIn[37] = 1'b1;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R3 rising edge latches");
    expRd(SEL_RAW, 0, 32'h0, "R9 line 37 not in word 0");
    lineIn[37] = 1'b0;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R11 latch holds after input falls");

    // R5 / R8 masking and request timing
    wr(SEL_EN, 1, 32'h20);
    expRd(SEL_MASKED, 1, 32'h20, "R5 masked shows enabled line");
    expIrq(1'b0, "R8 irq not yet registered");
    tick();
    expIrq(1'b1, "R8 irq one cycle after masked");
    wr(SEL_EN, 1, 32'h0);
    expRd(SEL_MASKED, 1, 32'h0, "R5 masked blocked");
    expRd(SEL_RAW, 1, 32'h20, "R5 latch kept while masked");
    tick();
    expIrq(1'b0, "R8 irq drops after mask");
    wr(SEL_EN, 1, 32'h20);

    // R6 acknowledge rules
    wr(SEL_CLR, 1, 32'h20);
    expRd(SEL_RAW, 1, 32'h0, "R6 clear bit 0->1 acks");
    tick();
    expIrq(1'b0, "R8 irq low after ack");
    lineIn[37] = 1'b1;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R3 second rising edge");
    wr(SEL_CLR, 1, 32'h20);
    expRd(SEL_RAW, 1, 32'h20, "R6 writing 1 over 1 does not ack");
    wr(SEL_CLR, 1, 32'h0);
    expRd(SEL_RAW, 1, 32'h20, "R6 writing 0 does not ack");
    wr(SEL_CLR, 1, 32'h20);
    expRd(SEL_RAW, 1, 32'h0, "R6 zero then one acks");

    // R7 edge in same cycle as acknowledge
    lineIn[37] = 1'b0;
    tick();
    expRd(SEL_RAW, 1, 32'h0, "R3 falling ignored with rising polarity");
    lineIn[37] = 1'b1;
    tick();
    lineIn[37] = 1'b0;
    tick();
    wr(SEL_CLR, 1, 32'h0);
    busWe = 1'b1; busAddr = mkAddr(SEL_CLR, 1); busWdata = 32'h20;
    lineIn[37] = 1'b1;
    tick();
    busWe = 1'b0;
    expRd(SEL_RAW, 1, 32'h20, "R7 edge wins over ack");
    ack(1, 32'h20);
    expRd(SEL_RAW, 1, 32'h0, "R6 ack after collision");

    // R3 falling polarity
    wr(SEL_POL, 1, 32'hFFFF_FFDF);
    lineIn[37] = 1'b0;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R3 falling edge latches with low polarity");
    ack(1, 32'h20);
    lineIn[37] = 1'b1;
    tick();
    expRd(SEL_RAW, 1, 32'h0, "R3 rising ignored with low polarity");

    // R10 polarity change clears latch
    lineIn[37] = 1'b0;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R3 falling edge latches again");
    wr(SEL_POL, 1, 32'hFFFF_FFFF);
    expRd(SEL_RAW, 1, 32'h0, "R10 polarity change clears latch");

    // R4 both edges
    lineIn[37] = 1'b1;
    tick();
    ack(1, 32'h20);
    wr(SEL_BOTH, 1, 32'h20);
    lineIn[37] = 1'b0;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R4 both-edge latches on fall");
    ack(1, 32'h20);
    lineIn[37] = 1'b1;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R4 both-edge latches on rise");
    wr(SEL_POL, 1, 32'hFFFF_FFDF);
    lineIn[37] = 1'b0;
    tick();
    ack(1, 32'h20);
    expRd(SEL_RAW, 1, 32'h0, "R4 latch empty before rise");
    lineIn[37] = 1'b1;
    tick();
    expRd(SEL_RAW, 1, 32'h20, "R4 rise latches despite low polarity");
    wr(SEL_BOTH, 0, 32'h8);
    lineIn[3] = 1'b1;
    expRd(SEL_RAW, 0, 32'h8, "R4 both-edge ignored in level mode");

    // R8 request from a level line
    ack(1, 32'h20);
    tick();
    expIrq(1'b0, "R8 irq idle");
    wr(SEL_EN, 0, 32'h8);
    expRd(SEL_MASKED, 0, 32'h8, "R5 level line masked status");
    expIrq(1'b0, "R8 irq registered, not yet high");
    tick();
    expIrq(1'b1, "R8 level line raises irq");
    lineIn[3] = 1'b0;
    expIrq(1'b1, "R8 irq holds until next edge");
    tick();
    expIrq(1'b0, "R8 irq drops after level falls");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule